// File: doc/BRIEF.md
# Signal Chain Calibration Sequencer

This block runs the digital side of calibrating an amplifier placed in front of an ADC. On a calibration request it steers two 2:1 analog selectors through three routings:

- the reference source fed straight to the converter,
- the amplifier input tied to ground,
- the reference passed through the amplifier.

For each routing it throws away a few settling samples and then averages a power-of-two number of readings. This gives three values: the direct reading X, the offset OS and the through-amplifier reading Y. It forms the offset-free reading Y - OS. With a sequential divider it computes the correction ratio I*X/(Y - OS) in unsigned Q1.15, where I is the ideal amplifier gain. It then writes the ratio and the offset to a nonvolatile store through a simple write port.

An apply request reads both stored words back. In a single write it programs an external gain/offset corrector with three values:

- the gain word,
- a valid-bit count of 15,
- the current corrector offset plus the stored offset.

It then turns gain correction on. Gain correction is always switched off before the through-amplifier routing is selected, so the amplifier reading is taken uncorrected.

Top module: `sigchain_cal_seq`

## Requirements
- R1: After reset `busy`, `muxASel`, `muxBSel`, `gainCorrEn`, `nvmWrEn`, `nvmRdEn` and `corrWr` are all 0. While idle, the selectors rest at 0/0 and no write is issued.
- R2: A calibration first routes the reference directly, with `muxBSel`=0 and `muxASel`=0. The averaged reading taken there is X.
- R3: The second routing is `muxASel`=1, `muxBSel`=1, which grounds the amplifier input. The averaged reading taken there is OS.
- R4: `gainCorrEn` is driven to 0 at least one full cycle before `muxASel` falls to 0 with `muxBSel`=1 (the through-amplifier routing). The averaged reading taken there is Y. `gainCorrEn` stays 0 after a calibration.
- R5: After each routing change, the first SETTLE_N samples with `adcValid`=1 are discarded. The next 2^AVG_LOG2 such samples are summed, and the sum is shifted right arithmetically by AVG_LOG2 (floor). Cycles with `adcValid`=0 are ignored.
- R6: The ratio equals floor(IDEAL_GAIN*X*32768/(Y-OS)). It saturates to 0xFFFF when that value is 65536 or more, and it is 0 when X <= 0.
- R7: A successful calibration makes exactly two writes on consecutive cycles. The first goes to address RATIO_ADDR (0) with the ratio zero-extended to 24 bits. The second goes to OS_ADDR (1) with OS sign-extended to 24 bits. `done` pulses with the second write.
- R8: If Y-OS <= 0, `error` pulses for one cycle. No write is made, `done` is not raised, and the block returns to idle.
- R9: An apply makes two reads: address 0 first, then address 1. Read data is taken one cycle after `nvmRdEn`. Next comes one `corrWr` cycle carrying three values: `corrGain` = stored ratio, `corrValidBits` = 15, and `corrOffsetOut` = (`corrOffsetIn` + stored offset) mod 2^24. `done` pulses in that cycle, and `gainCorrEn` is 1 from the next cycle on.
- R10: `busy` is 1 from the cycle after an accepted start through the `done` or `error` cycle, and 0 otherwise. `done` and `error` last one cycle.
- R11: Start requests are ignored while busy. When `startCal` and `startApply` arrive together in idle, the calibration runs and no apply takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startCal | input | 1 | Calibration request pulse |
| startApply | input | 1 | Apply request pulse |
| adcValid | input | 1 | Converter sample strobe |
| adcData | input | ADC_W | Signed converter sample |
| muxASel | output | 1 | First selector: 0 reference, 1 ground |
| muxBSel | output | 1 | Second selector: 0 direct, 1 via amplifier |
| gainCorrEn | output | 1 | Gain correction enable |
| nvmWrEn | output | 1 | Store write strobe |
| nvmWrAddr | output | NVM_AW | Store write address |
| nvmWrData | output | OFS_W | Store write data |
| nvmRdEn | output | 1 | Store read strobe |
| nvmRdAddr | output | NVM_AW | Store read address |
| nvmRdData | input | OFS_W | Store read data, one cycle after read |
| corrOffsetIn | input | OFS_W | Current corrector offset |
| corrWr | output | 1 | Corrector write strobe |
| corrGain | output | 16 | Gain word, Q1.15 |
| corrValidBits | output | 4 | Valid-bit count for the gain word |
| corrOffsetOut | output | OFS_W | New corrector offset |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished pulse |
| error | output | 1 | Non-positive Y-OS pulse |

## Verification
Two request lines can collide. The bench raises `startCal` and `startApply` in the same idle cycle and expects both store writes but no corrector write. It also fires both requests in the middle of a running calibration and expects no corrector write and an unchanged result. A sweep over X, OS and Y-OS exercises the normal ratio, saturation, zero for non-positive X and the error path, with each expected value computed arithmetically from the sample pattern. Running a calibration after an apply has turned correction on checks that the enable is dropped ahead of the through-amplifier routing.

// File: rtl/scs_pkg.sv
package scs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_AVG,
    ST_LATCH,
    ST_GOFF,
    ST_CHECK,
    ST_DIV,
    ST_WR_RATIO,
    ST_WR_OS,
    ST_AP_RD0,
    ST_AP_RD1,
    ST_AP_LDOS,
    ST_AP_WR
  } seqState_t;

  typedef enum logic [1:0] {
    STEP_REF  = 2'd0,
    STEP_ZERO = 2'd1,
    STEP_THRU = 2'd2
  } calStep_t;

  typedef struct packed {
    logic accClr;
    logic accEn;
    logic latchX;
    logic latchOs;
    logic latchY;
    logic divStart;
    logic ldRatio;
    logic ldOs;
  } dpStrobe_t;

endpackage

// File: rtl/scs_ctrl.sv
module scs_ctrl
  import scs_pkg::*;
#(
  parameter int SETTLE_N = 2,
  parameter int AVG_LOG2 = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startCal,
  input  logic      startApply,
  input  logic      adcValid,
  input  logic      ypPos,
  input  logic      divDone,
  output dpStrobe_t strobe,
  output logic      muxASel,
  output logic      muxBSel,
  output logic      gainCorrEn,
  output logic      busy,
  output logic      done,
  output logic      error,
  output logic      nvmWrEn,
  output logic      nvmWrSel,
  output logic      nvmRdEn,
  output logic      nvmRdSel,
  output logic      corrWr
);

  localparam int AVG_N = 1 << AVG_LOG2;
  localparam int MAX_N = (SETTLE_N > AVG_N) ? SETTLE_N : AVG_N;
  localparam int CNT_W = $clog2(MAX_N + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = (SETTLE_N == 0) ? '0 : CNT_W'(SETTLE_N - 1);
  localparam logic [CNT_W-1:0] AVG_LAST = CNT_W'(AVG_N - 1);

  seqState_t state;
  calStep_t  step;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      step       <= STEP_REF;
      cnt        <= '0;
      muxASel    <= 1'b0;
      muxBSel    <= 1'b0;
      gainCorrEn <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (startCal) begin
            step    <= STEP_REF;
            muxASel <= 1'b0;
            muxBSel <= 1'b0;
            state   <= ST_SETTLE;
          end else if (startApply) begin
            state <= ST_AP_RD0;
          end
        end
        ST_SETTLE: begin
          if (SETTLE_N == 0) begin
            state <= ST_AVG;
          end else if (adcValid) begin
            if (cnt == SETTLE_LAST) begin
              cnt   <= '0;
              state <= ST_AVG;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_AVG: begin
          if (adcValid) begin
            if (cnt == AVG_LAST) begin
              cnt   <= '0;
              state <= ST_LATCH;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_LATCH: begin
          case (step)
            STEP_REF: begin
              step    <= STEP_ZERO;
              muxASel <= 1'b1;
              muxBSel <= 1'b1;
              state   <= ST_SETTLE;
            end
            STEP_ZERO: begin
              gainCorrEn <= 1'b0;
              state      <= ST_GOFF;
            end
            default: state <= ST_CHECK;
          endcase
        end
        ST_GOFF: begin
          step    <= STEP_THRU;
          muxASel <= 1'b0;
          muxBSel <= 1'b1;
          state   <= ST_SETTLE;
        end
        ST_CHECK: begin
          if (ypPos) begin
            state <= ST_DIV;
          end else begin
            muxASel <= 1'b0;
            muxBSel <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        ST_DIV:      if (divDone) state <= ST_WR_RATIO;
        ST_WR_RATIO: state <= ST_WR_OS;
        ST_WR_OS: begin
          muxASel <= 1'b0;
          muxBSel <= 1'b0;
          state   <= ST_IDLE;
        end
        ST_AP_RD0:  state <= ST_AP_RD1;
        ST_AP_RD1:  state <= ST_AP_LDOS;
        ST_AP_LDOS: state <= ST_AP_WR;
        ST_AP_WR: begin
          gainCorrEn <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.accClr   = (state == ST_IDLE) || (state == ST_LATCH);
    strobe.accEn    = (state == ST_AVG) && adcValid;
    strobe.latchX   = (state == ST_LATCH) && (step == STEP_REF);
    strobe.latchOs  = (state == ST_LATCH) && (step == STEP_ZERO);
    strobe.latchY   = (state == ST_LATCH) && (step == STEP_THRU);
    strobe.divStart = (state == ST_CHECK) && ypPos;
    strobe.ldRatio  = (state == ST_AP_RD1);
    strobe.ldOs     = (state == ST_AP_LDOS);
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_WR_OS) || (state == ST_AP_WR);
  assign error    = (state == ST_CHECK) && !ypPos;
  assign nvmWrEn  = (state == ST_WR_RATIO) || (state == ST_WR_OS);
  assign nvmWrSel = (state == ST_WR_OS);
  assign nvmRdEn  = (state == ST_AP_RD0) || (state == ST_AP_RD1);
  assign nvmRdSel = (state == ST_AP_RD1);
  assign corrWr   = (state == ST_AP_WR);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!nvmWrEn && !corrWr && !muxASel && !muxBSel)); // R1
  AST_GAIN_OFF_THRU: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(muxASel) && muxBSel) |-> (!gainCorrEn && !$past(gainCorrEn))); // R4
  AST_ENABLE_AFTER_APPLY: assert property (@(posedge clk) disable iff (!rstN)
    corrWr |=> gainCorrEn); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

endmodule

// File: rtl/scs_datapath.sv
module scs_datapath
  import scs_pkg::*;
#(
  parameter int ADC_W      = 16,
  parameter int AVG_LOG2   = 4,
  parameter int IDEAL_GAIN = 24,
  parameter int IDEAL_W    = 8,
  parameter int OFS_W      = 24,
  parameter int GAIN_W     = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strobe,
  input  logic signed [ADC_W-1:0] adcData,
  input  logic [OFS_W-1:0]        nvmRdData,
  input  logic [OFS_W-1:0]        corrOffsetIn,
  output logic                    ypPos,
  output logic                    divDone,
  output logic [GAIN_W-1:0]       calRatio,
  output logic [OFS_W-1:0]        calOs,
  output logic [GAIN_W-1:0]       applyGain,
  output logic [OFS_W-1:0]        applyOffset
);

  localparam int ACC_W  = ADC_W + AVG_LOG2;
  localparam int DEN_W  = ADC_W + 1;
  localparam int FRAC_W = GAIN_W - 1;
  localparam int NUM_W  = IDEAL_W + ADC_W + FRAC_W;
  localparam int DCNT_W = $clog2(NUM_W + 1);

  // averaging accumulator
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] sampleExt;
  logic signed [ADC_W-1:0] avgVal;

  assign sampleExt = {{AVG_LOG2{adcData[ADC_W-1]}}, adcData};
  assign avgVal    = acc[ADC_W+AVG_LOG2-1:AVG_LOG2];

  always_ff @(posedge clk) begin
    if (!rstN || strobe.accClr) acc <= '0;
    else if (strobe.accEn)      acc <= acc + sampleExt;
  end

  // captured readings
  logic signed [ADC_W-1:0] xReg, osReg, yReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xReg  <= '0;
      osReg <= '0;
      yReg  <= '0;
    end else begin
      if (strobe.latchX)  xReg  <= avgVal;
      if (strobe.latchOs) osReg <= avgVal;
      if (strobe.latchY)  yReg  <= avgVal;
    end
  end

  logic signed [DEN_W-1:0] yPrime;
  assign yPrime = {yReg[ADC_W-1], yReg} - {osReg[ADC_W-1], osReg};
  assign ypPos  = !yPrime[DEN_W-1] && (|yPrime);

  // numerator IDEAL_GAIN * X scaled by 2^FRAC_W, zero for non-positive X
  logic             xPos;
  logic [NUM_W-1:0] xMag, numStart;
  assign xPos     = !xReg[ADC_W-1] && (|xReg);
  assign xMag     = NUM_W'(xReg[ADC_W-2:0]);
  assign numStart = xPos ? ((NUM_W'(IDEAL_GAIN) * xMag) << FRAC_W) : '0;

  // restoring divider, one quotient bit per cycle
  logic [NUM_W-1:0]  numSh, quo;
  logic [DEN_W-1:0]  rem, den;
  logic [DCNT_W-1:0] divCnt;
  logic              divActive;
  logic [DEN_W:0]    remTry;
  logic              qBit;
  logic [DEN_W-1:0]  remNext;

  assign remTry  = {rem, numSh[NUM_W-1]};
  assign qBit    = (remTry >= {1'b0, den});
  assign remNext = qBit ? DEN_W'(remTry - {1'b0, den}) : remTry[DEN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      numSh     <= '0;
      quo       <= '0;
      rem       <= '0;
      den       <= '0;
      divCnt    <= '0;
      divActive <= 1'b0;
      divDone   <= 1'b0;
    end else begin
      divDone <= 1'b0;
      if (strobe.divStart) begin
        numSh     <= numStart;
        quo       <= '0;
        rem       <= '0;
        den       <= yPrime;
        divCnt    <= DCNT_W'(NUM_W);
        divActive <= 1'b1;
      end else if (divActive) begin
        numSh  <= numSh << 1;
        quo    <= {quo[NUM_W-2:0], qBit};
        rem    <= remNext;
        divCnt <= divCnt - 1'b1;
        if (divCnt == DCNT_W'(1)) begin
          divActive <= 1'b0;
          divDone   <= 1'b1;
        end
      end
    end
  end

  assign calRatio = (|quo[NUM_W-1:GAIN_W]) ? '1 : quo[GAIN_W-1:0];
  assign calOs    = OFS_W'(osReg);

  // apply path
  logic [GAIN_W-1:0] ratioApply;
  logic [OFS_W-1:0]  osApply;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ratioApply <= '0;
      osApply    <= '0;
    end else begin
      if (strobe.ldRatio) ratioApply <= nvmRdData[GAIN_W-1:0];
      if (strobe.ldOs)    osApply    <= nvmRdData;
    end
  end

  assign applyGain   = ratioApply;
  assign applyOffset = corrOffsetIn + osApply;

  AST_OPERANDS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    divActive |-> !(strobe.latchX || strobe.latchOs || strobe.latchY)); // R6

endmodule

// File: rtl/sigchain_cal_seq.sv
module sigchain_cal_seq
  import scs_pkg::*;
#(
  parameter int ADC_W      = 16,
  parameter int AVG_LOG2   = 4,
  parameter int SETTLE_N   = 2,
  parameter int IDEAL_GAIN = 24,
  parameter int IDEAL_W    = 8,
  parameter int OFS_W      = 24,
  parameter int NVM_AW     = 4,
  parameter int RATIO_ADDR = 0,
  parameter int OS_ADDR    = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startCal,
  input  logic                    startApply,
  input  logic                    adcValid,
  input  logic signed [ADC_W-1:0] adcData,
  output logic                    muxASel,
  output logic                    muxBSel,
  output logic                    gainCorrEn,
  output logic                    nvmWrEn,
  output logic [NVM_AW-1:0]       nvmWrAddr,
  output logic [OFS_W-1:0]        nvmWrData,
  output logic                    nvmRdEn,
  output logic [NVM_AW-1:0]       nvmRdAddr,
  input  logic [OFS_W-1:0]        nvmRdData,
  input  logic [OFS_W-1:0]        corrOffsetIn,
  output logic                    corrWr,
  output logic [15:0]             corrGain,
  output logic [3:0]              corrValidBits,
  output logic [OFS_W-1:0]        corrOffsetOut,
  output logic                    busy,
  output logic                    done,
  output logic                    error
);

  localparam int GAIN_W = 16;
  localparam logic [NVM_AW-1:0] A_RATIO = NVM_AW'(RATIO_ADDR);
  localparam logic [NVM_AW-1:0] A_OS    = NVM_AW'(OS_ADDR);

  dpStrobe_t         strobe;
  logic              ypPos, divDone, nvmWrSel, nvmRdSel;
  logic [GAIN_W-1:0] calRatio;
  logic [OFS_W-1:0]  calOs;

  scs_ctrl #(
    .SETTLE_N (SETTLE_N),
    .AVG_LOG2 (AVG_LOG2)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startCal   (startCal),
    .startApply (startApply),
    .adcValid   (adcValid),
    .ypPos      (ypPos),
    .divDone    (divDone),
    .strobe     (strobe),
    .muxASel    (muxASel),
    .muxBSel    (muxBSel),
    .gainCorrEn (gainCorrEn),
    .busy       (busy),
    .done       (done),
    .error      (error),
    .nvmWrEn    (nvmWrEn),
    .nvmWrSel   (nvmWrSel),
    .nvmRdEn    (nvmRdEn),
    .nvmRdSel   (nvmRdSel),
    .corrWr     (corrWr)
  );

  scs_datapath #(
    .ADC_W      (ADC_W),
    .AVG_LOG2   (AVG_LOG2),
    .IDEAL_GAIN (IDEAL_GAIN),
    .IDEAL_W    (IDEAL_W),
    .OFS_W      (OFS_W),
    .GAIN_W     (GAIN_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .adcData      (adcData),
    .nvmRdData    (nvmRdData),
    .corrOffsetIn (corrOffsetIn),
    .ypPos        (ypPos),
    .divDone      (divDone),
    .calRatio     (calRatio),
    .calOs        (calOs),
    .applyGain    (corrGain),
    .applyOffset  (corrOffsetOut)
  );

  assign nvmWrAddr     = nvmWrSel ? A_OS : A_RATIO;
  assign nvmWrData     = nvmWrSel ? calOs : OFS_W'(calRatio);
  assign nvmRdAddr     = nvmRdSel ? A_OS : A_RATIO;
  assign corrValidBits = 4'(GAIN_W - 1);

endmodule

// File: tb/sigchain_cal_seq_tb.sv
module sigchain_cal_seq_tb;

  localparam int ADC_W = 16;
  localparam int AVG_LOG2 = 2;
  localparam int AVG_N = 1 << AVG_LOG2;
  localparam int SETTLE_N = 1;
  localparam int IDEAL = 24;
  localparam int OFS_W = 24;
  localparam int NVM_AW = 4;

  logic clk, rstN, startCal, startApply, adcValid;
  logic signed [ADC_W-1:0] adcData;
  logic muxASel, muxBSel, gainCorrEn, nvmWrEn, nvmRdEn, corrWr, busy, done, error;
  logic [NVM_AW-1:0] nvmWrAddr, nvmRdAddr;
  logic [OFS_W-1:0] nvmWrData, nvmRdData, corrOffsetIn, corrOffsetOut;
  logic [15:0] corrGain;
  logic [3:0] corrValidBits;

  sigchain_cal_seq #(
    .ADC_W(ADC_W), .AVG_LOG2(AVG_LOG2), .SETTLE_N(SETTLE_N), .IDEAL_GAIN(IDEAL),
    .IDEAL_W(8), .OFS_W(OFS_W), .NVM_AW(NVM_AW), .RATIO_ADDR(0), .OS_ADDR(1)
  ) u_dut (
    .clk(clk), .rstN(rstN), .startCal(startCal), .startApply(startApply),
    .adcValid(adcValid), .adcData(adcData), .muxASel(muxASel), .muxBSel(muxBSel),
    .gainCorrEn(gainCorrEn), .nvmWrEn(nvmWrEn), .nvmWrAddr(nvmWrAddr),
    .nvmWrData(nvmWrData), .nvmRdEn(nvmRdEn), .nvmRdAddr(nvmRdAddr),
    .nvmRdData(nvmRdData), .corrOffsetIn(corrOffsetIn), .corrWr(corrWr),
    .corrGain(corrGain), .corrValidBits(corrValidBits), .corrOffsetOut(corrOffsetOut),
    .busy(busy), .done(done), .error(error)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // nonvolatile store model, read data one cycle after the request
  logic [OFS_W-1:0] mem [16];
  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    nvmRdData = '0;
    forever begin
      @(posedge clk);
      if (nvmWrEn) mem[nvmWrAddr] <= nvmWrData;
      if (nvmRdEn) nvmRdData <= mem[nvmRdAddr];
    end
  end

  // converter model: junk during settle, known pattern afterwards
  int vX, vOs, vY;
  function automatic int delta(input int i);
    return ((i * 7) % 5) - 2;
  endfunction
  function automatic int expAvg(input int base);
    int s;
    s = 0;
    for (int i = 0; i < AVG_N; i++) s += base + delta(i);
    return s >>> AVG_LOG2;
  endfunction
  function automatic longint expRatio(input int x, input int yp);
    longint q;
    if (x <= 0) return 0;
    q = (longint'(IDEAL) * x * 32768) / yp;
    if (q > 65535) q = 65535;
    return q;
  endfunction

  initial begin
    int idx, cyc, base;
    logic [1:0] route, lastRoute;
    adcValid = 1'b0;
    adcData = '0;
    idx = 0;
    cyc = 0;
    lastRoute = 2'b00;
    forever begin
      @(negedge clk);
      cyc++;
      route = {muxASel, muxBSel};
      if (!busy) begin
        idx = 0;
        lastRoute = route;
        adcValid = 1'b0;
      end else begin
        if (route != lastRoute) begin
          idx = 0;
          lastRoute = route;
        end
        if (cyc % 3 == 0) begin
          base = !route[0] ? vX : (route[1] ? vOs : vY);
          adcValid = 1'b1;
          adcData = (idx < SETTLE_N) ? 16'sd30000 : ADC_W'(base + delta(idx - SETTLE_N));
          idx++;
        end else begin
          adcValid = 1'b0;
        end
      end
    end
  end

  // port monitor
  int wrCnt, corrCnt, nRoute, firstWrAddr;
  bit sawDone, sawErr, gateBad;
  logic [OFS_W-1:0] gotRatio, gotOs, gotOfs;
  logic [15:0] gotGain;
  logic [3:0] gotBits;
  logic [1:0] routes [8];

  task automatic clearFlags();
    wrCnt = 0; corrCnt = 0; nRoute = 0; firstWrAddr = -1;
    sawDone = 0; sawErr = 0; gateBad = 0;
  endtask

  initial begin
    logic prevA, prevGain, prevBusy;
    logic [1:0] lastR;
    prevA = 0; prevGain = 0; prevBusy = 0; lastR = 0;
    forever begin
      @(negedge clk);
      if (nvmWrEn) begin
        if (wrCnt == 0) firstWrAddr = int'(nvmWrAddr);
        wrCnt++;
        if (nvmWrAddr == 0) gotRatio = nvmWrData;
        else if (nvmWrAddr == 1) gotOs = nvmWrData;
      end
      if (done) sawDone = 1;
      if (error) sawErr = 1;
      if (corrWr) begin
        corrCnt++;
        gotGain = corrGain;
        gotBits = corrValidBits;
        gotOfs = corrOffsetOut;
      end
      if (busy && (!prevBusy || {muxASel, muxBSel} != lastR) && nRoute < 8) begin
        routes[nRoute] = {muxASel, muxBSel};
        nRoute++;
      end
      if (prevA && !muxASel && muxBSel && (gainCorrEn || prevGain)) gateBad = 1;
      lastR = {muxASel, muxBSel};
      prevA = muxASel;
      prevGain = gainCorrEn;
      prevBusy = busy;
    end
  end

  task automatic waitEnd();
    bit seen;
    seen = 0;
    for (int c = 0; c < 4000; c++) begin
      @(posedge clk);
      #1;
      if (sawDone || sawErr) begin
        seen = 1;
        break;
      end
    end
    chk(seen, "R10", "sequence end seen", seen, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R10", "busy after end", busy, 0);
  endtask

  task automatic pulse(input bit cal, input bit app);
    @(negedge clk);
    startCal = cal;
    startApply = app;
    @(negedge clk);
    startCal = 1'b0;
    startApply = 1'b0;
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
  endtask

  longint storedRatio, storedOs;

  task automatic runCal(input int x, input int os, input int y);
    int ex, eos, ey, yp;
    longint er;
    vX = x; vOs = os; vY = y;
    clearFlags();
    pulse(1, 0);
    waitEnd();
    ex = expAvg(x); eos = expAvg(os); ey = expAvg(y);
    yp = ey - eos;
    if (yp <= 0) begin
      chk(sawErr, "R8", "error raised", sawErr, 1);
      chk(wrCnt == 0, "R8", "no writes", wrCnt, 0);
      chk(!sawDone, "R8", "no done", sawDone, 0);
    end else begin
      er = expRatio(ex, yp);
      chk(gotRatio == OFS_W'(er), "R6", "ratio", gotRatio, er);
      chk(gotOs == OFS_W'(eos), "R3", "offset stored", gotOs, longint'(OFS_W'(eos)));
      chk(wrCnt == 2 && firstWrAddr == 0, "R7", "write count/order", wrCnt * 10 + firstWrAddr, 20);
      chk(!sawErr, "R8", "no error", sawErr, 0);
      storedRatio = er;
      storedOs = longint'(OFS_W'(eos));
    end
    chk(nRoute == 3 && routes[0] == 2'b00, "R2", "direct routing first", routes[0], 0);
    chk(routes[1] == 2'b11, "R3", "ground routing second", routes[1], 3);
    chk(routes[2] == 2'b01, "R4", "amplifier routing third", routes[2], 1);
    chk(!gateBad, "R4", "gain off before amplifier routing", gateBad, 0);
    chk(gainCorrEn == 1'b0, "R4", "gain enable after calibration", gainCorrEn, 0);
  endtask

  task automatic runApply(input logic [OFS_W-1:0] cur);
    logic [OFS_W-1:0] eo;
    corrOffsetIn = cur;
    clearFlags();
    pulse(0, 1);
    waitEnd();
    eo = cur + OFS_W'(storedOs);
    chk(corrCnt == 1, "R9", "one corrector write", corrCnt, 1);
    chk(gotGain == 16'(storedRatio), "R9", "gain word", gotGain, storedRatio);
    chk(gotBits == 4'd15, "R9", "valid bits", gotBits, 15);
    chk(gotOfs == eo, "R9", "offset sum", gotOfs, eo);
    chk(gainCorrEn == 1'b1, "R9", "gain enabled", gainCorrEn, 1);
    chk(wrCnt == 0, "R9", "no store writes", wrCnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int xs [3];
    int oss [3];
    int dys [3];
    xs = '{1000, 4000, -500};
    oss = '{0, 37, -250};
    dys = '{30000, 23000, 1};
    rstN = 1'b0; startCal = 1'b0; startApply = 1'b0; corrOffsetIn = '0;
    vX = 0; vOs = 0; vY = 0; storedRatio = 0; storedOs = 0;
    clearFlags();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0, "R1", "busy at reset", busy, 0);
    chk(muxASel == 0 && muxBSel == 0, "R1", "selectors at reset", {muxASel, muxBSel}, 0);
    chk(gainCorrEn == 0, "R1", "gain enable at reset", gainCorrEn, 0);
    chk(!nvmWrEn && !nvmRdEn && !corrWr, "R1", "strobes at reset", {nvmWrEn, nvmRdEn, corrWr}, 0);

    // sweep: averaging R5, ratio R6 incl. saturation and X<=0
    foreach (xs[i]) foreach (oss[j]) foreach (dys[k])
      runCal(xs[i], oss[j], oss[j] + dys[k]);

    // error path R8: Y-OS zero and negative
    runCal(1000, 200, 200);
    runCal(1000, 200, 100);

    // apply R9 after a valid calibration, then store-injected values
    runCal(1000, 37, 23037);
    runApply(24'h000100);
    @(negedge clk);
    mem[0] = 24'h008123; mem[1] = 24'hFFFF38;
    storedRatio = 'h8123; storedOs = 'hFFFF38;
    runApply(24'd100);
    @(negedge clk);
    mem[1] = 24'h000040; storedOs = 'h40;
    runApply(24'hFFFFF0);

    // calibration with correction on must drop it first R4
    runCal(1000, 0, 30000);

    // simultaneous requests R11
    vX = 1000; vOs = 0; vY = 23000;
    clearFlags();
    pulse(1, 1);
    waitEnd();
    chk(wrCnt == 2 && corrCnt == 0, "R11", "both starts: calibration only",
        wrCnt * 10 + corrCnt, 20);

    // requests while busy R11
    clearFlags();
    pulse(1, 0);
    repeat (10) @(negedge clk);
    startApply = 1'b1; startCal = 1'b1;
    @(negedge clk);
    startApply = 1'b0; startCal = 1'b0;
    waitEnd();
    chk(corrCnt == 0, "R11", "apply ignored while busy", corrCnt, 0);
    chk(gotRatio == OFS_W'(expRatio(expAvg(1000), expAvg(23000) - expAvg(0))), "R11",
        "result unaffected", gotRatio, expRatio(expAvg(1000), expAvg(23000) - expAvg(0)));

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule